// File: doc/BRIEF.md
# I2C Transfer Status Flag Controller

This block keeps the four status flags of one I2C channel and moves data between the channel's holding registers and its shift register. The flags are transmit-empty, transmit-end, receive-full and NACK-seen. A separate bit engine reports SCL rising edges with their position in the byte (1 to 9), the acknowledge level sampled on the ninth edge, start/restart and stop detection, and address match. The CPU side writes transmit bytes, reads received bytes, writes the direction bit, reads and writes the status flags, and can issue a soft reset.

A small phase machine follows the bus. It has four states. `PH_IDLE` is the bus-free state. `PH_ADDR` covers the address byte. `PH_DATA` covers data bytes. `PH_HALT` means the channel is aborted after a NACK. Its transitions are:
- `PH_IDLE` to `PH_ADDR` on start.
- `PH_ADDR` to `PH_DATA` on the ninth SCL edge.
- `PH_ADDR` or `PH_DATA` back to `PH_ADDR` on restart.
- `PH_ADDR` or `PH_DATA` to `PH_IDLE` on stop.
- `PH_ADDR` or `PH_DATA` to `PH_HALT` on a NACK while abort is enabled. This has the highest priority.
- `PH_HALT` to `PH_IDLE` in the cycle after the NACK flag reads 0.

While the machine is in `PH_HALT`, the abort output is high and no byte moves in either direction.

The three software-clearable flags need a read before a clear. A status read that returns 1 arms a per-flag "seen" bit. A later status write of 0 to that bit clears the flag and consumes the arming.

Top module: `i2c_xfer_flags`

## Requirements
- R1: After hard reset or a soft-reset strobe, all four flags read 0 and abort is low. The flag order is bit 0 transmit-empty, bit 1 transmit-end, bit 2 receive-full, bit 3 NACK.
- R2: A status write with bit N equal to 0 clears flag N (N = 1, 2, 3) only if a status read has returned that flag as 1 since the last such write. A write of 0 without that read, or a write of 1, leaves the flag unchanged.
- R3: When a hardware set event and a clearing status write hit the same flag in the same cycle, the flag ends at 1.
- R4: Transmit-empty sets when a byte is loaded into the shift register, when the direction is written to transmit (value 1), or on address match in `PH_ADDR` while transmitting. It clears on a transmit-data write or when the direction is written to receive (value 0). A status write of 0 never clears it.
- R5: Transmit-end sets on the ninth SCL edge, in `PH_ADDR`/`PH_DATA` while transmitting, if transmit-empty was 1. It clears on a transmit-data write or on stop.
- R6: While receiving in `PH_DATA`, the shift byte moves to the receive data output and receive-full sets. This happens on the eighth SCL edge when the edge-select bit is 0, and on the ninth when it is 1.
- R7: Receive-full sets on address match in `PH_ADDR` while receiving. It clears when the receive data is read.
- R8: With abort enabled, a NACK sampled on the ninth edge while transmitting in `PH_ADDR`/`PH_DATA` sets the NACK flag and raises abort. With abort disabled, the NACK flag does not set.
- R9: While aborted, no byte is loaded for transmit and no received byte is moved. Neither transmit-end nor receive-full sets from SCL edges.
- R10: A byte that is pending at the NACK edge is still loaded into the shift register on that edge, but transmit-empty stays 0.
- R11: The phase machine follows the transitions listed above. Received bytes move only in `PH_DATA`. Abort falls one cycle after the NACK flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Soft/internal reset strobe |
| cfg_nack_abort_i | input | 1 | Enable abort on NACK |
| cfg_rx_at9_i | input | 1 | Receive-full edge select: 0 = 8th, 1 = 9th |
| scl_rise_i | input | 1 | SCL rising-edge strobe |
| scl_cnt_i | input | CNT_W | Position of this edge in the byte, 1 to 9 |
| nack_seen_i | input | 1 | Acknowledge bit sampled high on the 9th edge |
| start_i | input | 1 | Start or restart detected |
| stop_i | input | 1 | Stop detected |
| addr_match_i | input | 1 | Slave address matched |
| rx_shift_i | input | DATA_W | Byte assembled by the bit engine |
| cpu_tx_wr_i | input | 1 | Transmit-data write strobe |
| cpu_wdata_i | input | DATA_W | CPU write data (status writes use bits 3:0) |
| cpu_rx_rd_i | input | 1 | Receive-data read strobe |
| cpu_st_rd_i | input | 1 | Status read strobe |
| cpu_st_wr_i | input | 1 | Status write strobe |
| cpu_dir_wr_i | input | 1 | Direction write strobe |
| cpu_dir_tx_i | input | 1 | Direction value: 1 transmit, 0 receive |
| flags_o | output | 4 | Status flags |
| abort_o | output | 1 | Transfer aborted |
| tx_shift_o | output | DATA_W | Byte loaded into the shift register |
| rx_data_o | output | DATA_W | Receive holding register |

## Verification
The bench targets the NACK edge with a byte pending. A design that lets transmit-empty rise there would tell software to refill a buffer that has already been lost. A design that drops the pending load would leave the shift register stale. It also hits a receive move on the same cycle as an armed clear write, where a clear-wins design would lose a received byte. It covers a clear write that is repeated without a fresh read, and a transmit-empty clear attempt from software; a design that ignores the arming or the per-flag permission would drop flags at random. Restarts and the eighth/ninth edge select are exercised so that a byte moved during the address phase or on the wrong edge shows up in the receive data compare.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

    localparam int NFLAG    = 4;
    localparam int FLG_TDRE = 0;
    localparam int FLG_TEND = 1;
    localparam int FLG_RDRF = 2;
    localparam int FLG_NACK = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_HALT = 2'd3
    } phase_t;

endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell #(
    parameter bit SW_CLR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic set_i,
    input  logic hclr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);

    logic flag_q;
    logic sw_clr;

    generate
        if (SW_CLR) begin : g_armed
            logic seen_q;
            logic wr_zero;
            assign wr_zero = wr_i && !wbit_i;
            assign sw_clr  = wr_zero && seen_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    seen_q <= 1'b0;
                end else if (soft_rst_i) begin
                    seen_q <= 1'b0;
                end else begin
                    // armed by a read of 1, consumed by any zero write, dropped when flag falls
                    seen_q <= (set_i || (flag_q && !hclr_i && !sw_clr))
                              && !wr_zero && (seen_q || (rd_i && flag_q));
                end
            end
        end else begin : g_hw_only
            logic unused_cpu;
            assign unused_cpu = rd_i ^ wr_i ^ wbit_i;
            assign sw_clr     = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (soft_rst_i) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= set_i || (flag_q && !hclr_i && !sw_clr);
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/i2c_flag_phase_fsm.sv
module i2c_flag_phase_fsm
    import i2c_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   soft_rst_i,
    input  logic   start_i,
    input  logic   stop_i,
    input  logic   edge_last_i,
    input  logic   nack_evt_i,
    input  logic   nack_flag_i,
    output phase_t phase_o,
    output logic   abort_o
);

    phase_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else if (soft_rst_i) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (start_i) state_d = PH_ADDR;
            end
            PH_ADDR, PH_DATA: begin
                if (nack_evt_i)                          state_d = PH_HALT;
                else if (start_i)                        state_d = PH_ADDR;
                else if (stop_i)                         state_d = PH_IDLE;
                else if (edge_last_i && state_q == PH_ADDR) state_d = PH_DATA;
            end
            PH_HALT: begin
                if (!nack_flag_i) state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    assign phase_o = state_q;
    assign abort_o = (state_q == PH_HALT);

endmodule

// File: rtl/i2c_flag_datapath.sv
module i2c_flag_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              dir_wr_i,
    input  logic              dir_tx_i,
    input  logic              tx_load_i,
    input  logic              rx_move_i,
    input  logic [DATA_W-1:0] rx_shift_i,
    output logic              tx_full_o,
    output logic              dir_tx_o,
    output logic [DATA_W-1:0] tx_shift_o,
    output logic [DATA_W-1:0] rx_data_o
);

    logic [DATA_W-1:0] tx_hold_q;
    logic [DATA_W-1:0] tx_shift_q;
    logic [DATA_W-1:0] rx_hold_q;
    logic              tx_full_q;
    logic              dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold_q  <= '0;
            tx_shift_q <= '0;
            rx_hold_q  <= '0;
        end else begin
            if (tx_wr_i)   tx_hold_q  <= wdata_i;
            if (tx_load_i) tx_shift_q <= tx_hold_q;
            if (rx_move_i) rx_hold_q  <= rx_shift_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_full_q <= 1'b0;
            dir_q     <= 1'b0;
        end else if (soft_rst_i) begin
            tx_full_q <= 1'b0;
            dir_q     <= 1'b0;
        end else begin
            if (tx_wr_i)        tx_full_q <= 1'b1;
            else if (tx_load_i) tx_full_q <= 1'b0;
            if (dir_wr_i)       dir_q     <= dir_tx_i;
        end
    end

    assign tx_full_o  = tx_full_q;
    assign dir_tx_o   = dir_q;
    assign tx_shift_o = tx_shift_q;
    assign rx_data_o  = rx_hold_q;

endmodule

// File: rtl/i2c_xfer_flags.sv
module i2c_xfer_flags
    import i2c_flag_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 4,
    parameter int LAST_EDGE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              cfg_nack_abort_i,
    input  logic              cfg_rx_at9_i,
    input  logic              scl_rise_i,
    input  logic [CNT_W-1:0]  scl_cnt_i,
    input  logic              nack_seen_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              addr_match_i,
    input  logic [DATA_W-1:0] rx_shift_i,
    input  logic              cpu_tx_wr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              cpu_rx_rd_i,
    input  logic              cpu_st_rd_i,
    input  logic              cpu_st_wr_i,
    input  logic              cpu_dir_wr_i,
    input  logic              cpu_dir_tx_i,
    output logic [3:0]        flags_o,
    output logic              abort_o,
    output logic [DATA_W-1:0] tx_shift_o,
    output logic [DATA_W-1:0] rx_data_o
);

    localparam int EARLY_EDGE = LAST_EDGE - 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(LAST_EDGE);
    localparam logic [CNT_W-1:0] CNT_EARLY = CNT_W'(EARLY_EDGE);

    phase_t           phase;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] hclr_v;
    logic             tx_full;
    logic             dir_tx;
    logic             edge_last;
    logic             edge_rx;
    logic             in_xfer;
    logic             nack_evt;
    logic             tx_load;
    logic             rx_move;
    logic             adr_hit;

    assign edge_last = scl_rise_i && (scl_cnt_i == CNT_LAST);
    assign edge_rx   = scl_rise_i && (scl_cnt_i == (cfg_rx_at9_i ? CNT_LAST : CNT_EARLY));
    assign in_xfer   = (phase == PH_ADDR) || (phase == PH_DATA);
    assign adr_hit   = addr_match_i && (phase == PH_ADDR);

    assign nack_evt  = edge_last && in_xfer && dir_tx && nack_seen_i && cfg_nack_abort_i;
    assign tx_load   = edge_last && in_xfer && dir_tx && tx_full;
    assign rx_move   = edge_rx && (phase == PH_DATA) && !dir_tx;

    always_comb begin
        set_v  = '0;
        hclr_v = '0;
        // a load concurrent with a new write leaves the buffer full; a NACK edge hides the load
        set_v[FLG_TDRE]  = (tx_load && !nack_evt && !cpu_tx_wr_i)
                         || (cpu_dir_wr_i && cpu_dir_tx_i)
                         || (adr_hit && dir_tx);
        hclr_v[FLG_TDRE] = cpu_tx_wr_i || (cpu_dir_wr_i && !cpu_dir_tx_i);
        set_v[FLG_TEND]  = edge_last && in_xfer && dir_tx && flag_q[FLG_TDRE];
        hclr_v[FLG_TEND] = cpu_tx_wr_i || stop_i;
        set_v[FLG_RDRF]  = rx_move || (adr_hit && !dir_tx);
        hclr_v[FLG_RDRF] = cpu_rx_rd_i;
        set_v[FLG_NACK]  = nack_evt;
        hclr_v[FLG_NACK] = 1'b0;
    end

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            i2c_flag_cell #(
                .SW_CLR (i != FLG_TDRE)
            ) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .soft_rst_i (soft_rst_i),
                .set_i      (set_v[i]),
                .hclr_i     (hclr_v[i]),
                .rd_i       (cpu_st_rd_i),
                .wr_i       (cpu_st_wr_i),
                .wbit_i     (cpu_wdata_i[i]),
                .flag_o     (flag_q[i])
            );
        end
    endgenerate

    i2c_flag_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst_i),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .edge_last_i (edge_last),
        .nack_evt_i  (nack_evt),
        .nack_flag_i (flag_q[FLG_NACK]),
        .phase_o     (phase),
        .abort_o     (abort_o)
    );

    i2c_flag_datapath #(
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .tx_wr_i    (cpu_tx_wr_i),
        .wdata_i    (cpu_wdata_i),
        .dir_wr_i   (cpu_dir_wr_i),
        .dir_tx_i   (cpu_dir_tx_i),
        .tx_load_i  (tx_load),
        .rx_move_i  (rx_move),
        .rx_shift_i (rx_shift_i),
        .tx_full_o  (tx_full),
        .dir_tx_o   (dir_tx),
        .tx_shift_o (tx_shift_o),
        .rx_data_o  (rx_data_o)
    );

    assign flags_o = flag_q;

endmodule

// File: rtl/i2c_xfer_flags_chk.sv
module i2c_xfer_flags_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst_i,
    input logic              scl_rise_i,
    input logic              addr_match_i,
    input logic              cpu_tx_wr_i,
    input logic [DATA_W-1:0] cpu_wdata_i,
    input logic              cpu_rx_rd_i,
    input logic              cpu_st_wr_i,
    input logic              cpu_dir_wr_i,
    input logic              cpu_dir_tx_i,
    input logic [3:0]        flags_o,
    input logic              abort_o,
    input logic [DATA_W-1:0] tx_shift_o,
    input logic [DATA_W-1:0] rx_data_o
);

    p_soft_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (flags_o == 4'b0000 && !abort_o));

    p_rdrf_fall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[2]) |-> $past(cpu_rx_rd_i || soft_rst_i || (cpu_st_wr_i && !cpu_wdata_i[2])));

    p_tdre_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[0]) |-> $past((cpu_dir_wr_i && cpu_dir_tx_i) || addr_match_i || scl_rise_i));

    p_tdre_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[0]) |-> $past(cpu_tx_wr_i || soft_rst_i || (cpu_dir_wr_i && !cpu_dir_tx_i)));

    p_tend_after_tdre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[1]) |-> $past(flags_o[0]));

    p_rdrf_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[2]) |-> $past(scl_rise_i || addr_match_i));

    p_abort_with_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[3] |-> abort_o);

    p_frozen_in_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> ($stable(tx_shift_o) && $stable(rx_data_o)));

    p_nack_hides_tdre_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags_o[3]) && $past(!flags_o[0]) && !$past(cpu_dir_wr_i) && !$past(addr_match_i))
        |-> !flags_o[0]);

endmodule

bind i2c_xfer_flags i2c_xfer_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst_i),
    .scl_rise_i   (scl_rise_i),
    .addr_match_i (addr_match_i),
    .cpu_tx_wr_i  (cpu_tx_wr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rx_rd_i  (cpu_rx_rd_i),
    .cpu_st_wr_i  (cpu_st_wr_i),
    .cpu_dir_wr_i (cpu_dir_wr_i),
    .cpu_dir_tx_i (cpu_dir_tx_i),
    .flags_o      (flags_o),
    .abort_o      (abort_o),
    .tx_shift_o   (tx_shift_o),
    .rx_data_o    (rx_data_o)
);

// File: tb/i2c_xfer_flags_test.sv
`timescale 1ns/1ps
module i2c_xfer_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst_i = 0, cfg_nack_abort_i = 0, cfg_rx_at9_i = 0;
    logic       scl_rise_i = 0, nack_seen_i = 0, start_i = 0, stop_i = 0, addr_match_i = 0;
    logic [3:0] scl_cnt_i = 0;
    logic [7:0] rx_shift_i = 0, cpu_wdata_i = 0;
    logic       cpu_tx_wr_i = 0, cpu_rx_rd_i = 0, cpu_st_rd_i = 0, cpu_st_wr_i = 0;
    logic       cpu_dir_wr_i = 0, cpu_dir_tx_i = 0;
    logic [3:0] flags_o;
    logic       abort_o;
    logic [7:0] tx_shift_o, rx_data_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    i2c_xfer_flags uut (.*);

    // ---------------- behavioural reference ----------------
    bit   mf[4];
    bit   mseen[4];
    int   mph = 0;            // 0 idle, 1 address, 2 data, 3 halted
    bit   mdir = 0, mfull = 0;
    int   mhold = 0, mshift = 0, mrx = 0;

    always @(posedge clk) begin
        bit e9, erx, xfer, nk, ld, mv, hit;
        bit st[4];
        bit hc[4];
        bit nfl[4];
        bit nsn[4];
        int nph;
        if (!rst_n) begin
            foreach (mf[i]) begin mf[i] = 0; mseen[i] = 0; end
            mph = 0; mdir = 0; mfull = 0; mhold = 0; mshift = 0; mrx = 0;
        end else begin
            e9   = scl_rise_i && scl_cnt_i == 9;
            erx  = scl_rise_i && scl_cnt_i == (cfg_rx_at9_i ? 9 : 8);
            xfer = (mph == 1 || mph == 2);
            hit  = addr_match_i && mph == 1;
            nk   = e9 && xfer && mdir && nack_seen_i && cfg_nack_abort_i;
            ld   = e9 && xfer && mdir && mfull;
            mv   = erx && mph == 2 && !mdir;
            st[0] = (ld && !nk && !cpu_tx_wr_i) || (cpu_dir_wr_i && cpu_dir_tx_i) || (hit && mdir);
            hc[0] = cpu_tx_wr_i || (cpu_dir_wr_i && !cpu_dir_tx_i);
            st[1] = e9 && xfer && mdir && mf[0];
            hc[1] = cpu_tx_wr_i || stop_i;
            st[2] = mv || (hit && !mdir);
            hc[2] = cpu_rx_rd_i;
            st[3] = nk;
            hc[3] = 0;
            for (int i = 0; i < 4; i++) begin
                bit w0;
                w0     = cpu_st_wr_i && !cpu_wdata_i[i] && (i != 0);
                nfl[i] = st[i] || (mf[i] && !hc[i] && !(w0 && mseen[i]));
                nsn[i] = nfl[i] && !w0 && (mseen[i] || (cpu_st_rd_i && mf[i]));
            end
            nph = mph;
            if (mph == 0) begin
                if (start_i) nph = 1;
            end else if (mph == 3) begin
                if (!mf[3]) nph = 0;
            end else begin
                if (nk) nph = 3;
                else if (start_i) nph = 1;
                else if (stop_i) nph = 0;
                else if (e9 && mph == 1) nph = 2;
            end
            if (ld) mshift = mhold;
            if (cpu_tx_wr_i) mhold = cpu_wdata_i;
            if (mv) mrx = rx_shift_i;
            if (cpu_tx_wr_i) mfull = 1; else if (ld) mfull = 0;
            if (cpu_dir_wr_i) mdir = cpu_dir_tx_i;
            for (int i = 0; i < 4; i++) begin mf[i] = nfl[i]; mseen[i] = nsn[i]; end
            mph = nph;
            if (soft_rst_i) begin
                foreach (mf[i]) begin mf[i] = 0; mseen[i] = 0; end
                mph = 0; mdir = 0; mfull = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the reference every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 tdre vs model", flags_o[0], mf[0]);
            chk("R5 tend vs model", flags_o[1], mf[1]);
            chk("R6 rdrf vs model", flags_o[2], mf[2]);
            chk("R8 nack vs model", flags_o[3], mf[3]);
            chk("R11 abort vs model", abort_o, (mph == 3));
            chk("R10 tx_shift vs model", tx_shift_o, mshift);
            chk("R6 rx_data vs model", rx_data_o, mrx);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
        soft_rst_i = 0; scl_rise_i = 0; nack_seen_i = 0; start_i = 0; stop_i = 0;
        addr_match_i = 0; cpu_tx_wr_i = 0; cpu_rx_rd_i = 0; cpu_st_rd_i = 0;
        cpu_st_wr_i = 0; cpu_dir_wr_i = 0;
    endtask

    task automatic scl(input int n, input bit nk);
        scl_rise_i = 1; scl_cnt_i = 4'(n); nack_seen_i = nk; step();
    endtask

    task automatic byte_edges(input bit nk);
        for (int n = 1; n <= 9; n++) scl(n, (n == 9) ? nk : 1'b0);
    endtask

    task automatic tx_write(input int d);
        cpu_tx_wr_i = 1; cpu_wdata_i = 8'(d); step();
    endtask

    task automatic st_read();
        cpu_st_rd_i = 1; step();
    endtask

    task automatic st_write(input int d);
        cpu_st_wr_i = 1; cpu_wdata_i = 8'(d); step();
    endtask

    task automatic dir_write(input bit tx);
        cpu_dir_wr_i = 1; cpu_dir_tx_i = tx; step();
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        chk("R1 flags after reset", flags_o, 0);
        chk("R1 abort after reset", abort_o, 0);

        // master transmit
        dir_write(1);
        chk("R4 tdre on dir tx", flags_o[0], 1);
        tx_write(8'hA5);
        chk("R4 tdre cleared by write", flags_o[0], 0);
        start_i = 1; step();
        byte_edges(0);
        chk("R4 tdre on load", flags_o[0], 1);
        chk("R4 byte loaded", tx_shift_o, 8'hA5);
        chk("R5 tend not set when tdre was 0", flags_o[1], 0);
        byte_edges(0);
        chk("R5 tend on 9th edge", flags_o[1], 1);
        tx_write(8'h3C);
        chk("R5 tend cleared by write", flags_o[1], 0);
        byte_edges(0);
        chk("R4 second load", tx_shift_o, 8'h3C);

        // NACK with a byte pending
        cfg_nack_abort_i = 1;
        tx_write(8'h77);
        byte_edges(1);
        chk("R8 nack flag", flags_o[3], 1);
        chk("R8 abort raised", abort_o, 1);
        chk("R10 pending byte moved", tx_shift_o, 8'h77);
        chk("R10 tdre held low", flags_o[0], 0);

        // aborted: no movement
        tx_write(8'h11);
        byte_edges(0);
        chk("R9 no load while aborted", tx_shift_o, 8'h77);
        chk("R9 no tend while aborted", flags_o[1], 0);

        // read-then-clear
        st_write(4'b0111);
        chk("R2 clear without read ignored", flags_o[3], 1);
        st_read();
        st_write(4'b1111);
        chk("R2 write of 1 keeps flag", flags_o[3], 1);
        st_read();
        st_write(4'b0111);
        chk("R2 armed clear", flags_o[3], 0);
        chk("R11 abort lags flag by one cycle", abort_o, 1);
        step();
        chk("R11 abort released", abort_o, 0);

        // slave receive
        dir_write(0);
        start_i = 1; step();
        addr_match_i = 1; step();
        chk("R7 rdrf on address match", flags_o[2], 1);
        cpu_rx_rd_i = 1; step();
        chk("R7 rdrf cleared by read", flags_o[2], 0);
        rx_shift_i = 8'h5A;
        scl(9, 0);
        cfg_rx_at9_i = 0;
        scl(8, 0);
        chk("R6 rdrf on 8th edge", flags_o[2], 1);
        chk("R6 byte on 8th edge", rx_data_o, 8'h5A);
        cpu_rx_rd_i = 1; step();
        cfg_rx_at9_i = 1; rx_shift_i = 8'hC3;
        scl(8, 0);
        chk("R6 no move on 8th when 9th selected", rx_data_o, 8'h5A);
        scl(9, 0);
        chk("R6 byte on 9th edge", rx_data_o, 8'hC3);
        chk("R6 rdrf on 9th edge", flags_o[2], 1);

        // set wins over an armed clear
        st_read();
        cfg_rx_at9_i = 0; rx_shift_i = 8'h96;
        scl_rise_i = 1; scl_cnt_i = 8; cpu_st_wr_i = 1; cpu_wdata_i = 8'h0B; step();
        chk("R3 set beats clear", flags_o[2], 1);
        chk("R3 byte still moved", rx_data_o, 8'h96);
        st_write(4'b1011);
        chk("R2 arming consumed", flags_o[2], 1);
        cpu_rx_rd_i = 1; step();

        // restart and stop
        start_i = 1; rx_shift_i = 8'h42; step();
        scl(8, 0);
        chk("R11 no move in address phase", rx_data_o, 8'h96);
        stop_i = 1; step();
        scl(9, 0);
        scl(8, 0);
        chk("R11 no move when idle", rx_data_o, 8'h96);

        // stop clears tend
        dir_write(1);
        start_i = 1; step();
        scl(9, 0);
        chk("R5 tend set in address phase", flags_o[1], 1);
        chk("R4 pending byte loaded", tx_shift_o, 8'h11);
        stop_i = 1; step();
        chk("R5 tend cleared by stop", flags_o[1], 0);

        // abort disabled
        cfg_nack_abort_i = 0;
        start_i = 1; step();
        scl(9, 1);
        chk("R8 no nack when disabled", flags_o[3], 0);
        chk("R8 no abort when disabled", abort_o, 0);

        // tdre not software-clearable
        st_read();
        st_write(4'b0000);
        chk("R4 tdre ignores status write", flags_o[0], 1);
        chk("R2 tend cleared after read", flags_o[1], 0);

        // soft reset
        cfg_nack_abort_i = 1;
        scl(9, 1);
        soft_rst_i = 1; step();
        chk("R1 flags after soft reset", flags_o, 0);
        chk("R1 abort after soft reset", abort_o, 0);

        // mixed traffic against the model
        for (int k = 0, cnt = 1; k < 3000; k++) begin
            scl_rise_i = ($urandom % 2) == 0;
            scl_cnt_i = 4'(cnt);
            if (scl_rise_i) cnt = (cnt == 9) ? 1 : cnt + 1;
            nack_seen_i      = ($urandom % 3) == 0;
            start_i          = ($urandom % 40) == 0;
            stop_i           = ($urandom % 40) == 0;
            addr_match_i     = ($urandom % 8) == 0;
            rx_shift_i       = 8'($urandom);
            cpu_wdata_i      = 8'($urandom);
            cpu_tx_wr_i      = ($urandom % 7) == 0;
            cpu_rx_rd_i      = ($urandom % 9) == 0;
            cpu_st_rd_i      = ($urandom % 4) == 0;
            cpu_st_wr_i      = ($urandom % 6) == 0;
            cpu_dir_wr_i     = ($urandom % 25) == 0;
            cpu_dir_tx_i     = ($urandom % 3) != 0;
            soft_rst_i       = ($urandom % 300) == 0;
            if ((k % 200) == 0) begin
                cfg_rx_at9_i     = 1'($urandom);
                cfg_nack_abort_i = 1'($urandom);
            end
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule